// File: doc/BRIEF.md
# Board Power and Thermal Supervisor

This block sits in the always-on management logic of a multi-FPGA board. It switches the enable of the main board supply and selects the I/O voltage delivered to the processing devices. Both are driven by commands from a host processor port. The block also watches active-low over-temperature alert lines from five remote sensors. Each sensor covers a group of four processing FPGAs, so twenty devices are covered in all. Because the supervisor runs from its own supply, it keeps working while main power is off.

An alert is synchronised and then filtered, and it is acted on only once the sensors have been configured, which is signalled by an armed input after boot. An accepted alert removes main power at once, without waiting for the host. It also latches a mask naming every group that tripped, and the block refuses to power up again until the host clears the fault while no alert is present. A per-device hot vector expands the group mask onto the twenty FPGAs. The status word packs the power state, the voltage selection, the fault mask and a rejected-write error bit.

Top module: `pwr_thermal_sup`

## Requirements
- R1: After reset, main power is off, the I/O voltage select is 0 (3.3 V single-ended), the fault mask is zero and the error bit is clear. The status word layout is: bit 0 power on, bit 1 voltage select, bits 6:2 fault mask (bit 2+g for group g), bit 7 error.
- R2: Command op 1 switches main power on when the block is armed and not faulted. Command op 2 switches it off. Either change is visible after the clock edge that samples the command.
- R3: A power-on command is ignored while the armed input is low.
- R4: Alert inputs are active low and pass through a two-flop synchroniser. An alert is accepted only after its synchronised level is active for 4 consecutive cycles, so a 4-cycle low pulse is accepted and a 3-cycle pulse is not. When an alert is held low from just before an edge, power is still on after the sixth edge and off after the seventh.
- R5: An accepted alert forces main power off and sets the mask bit of its group. Later accepted alerts add their bits to the mask, and the fault flag output is high while the mask is non-zero.
- R6: While a fault is latched, a power-on command is ignored.
- R7: Command op 4 clears the fault and mask only when every synchronised alert is inactive, and power then stays off. Otherwise the command has no effect.
- R8: Command op 3 sets the voltage select from cmd_data (0 = 3.3 V single-ended, 1 = 2.5 V differential) and clears the error bit while power is off. While power is on, the write is rejected, the selection is unchanged and the error bit is set.
- R9: fpga_hot bit j equals fault mask bit j/4.
- R10: While the armed input is low, alerts do not latch a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensors_armed | input | 1 | High once the sensors are configured |
| alert_n | input | 5 | Active-low over-temperature alerts, one per group |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 3 | Command code: 1 on, 2 off, 3 set voltage, 4 clear fault |
| cmd_data | input | 1 | Voltage select value for op 3 |
| main_pwr_en | output | 1 | Main supply enable |
| io_vsel | output | 1 | I/O voltage select, 1 selects 2.5 V differential |
| fault_flag | output | 1 | Latched thermal fault indication for the host |
| fpga_hot | output | 20 | Per-FPGA fault indication derived from the group mask |
| status | output | 8 | Packed status word |

## Verification
On every cycle, the assertions check the following. An accepted alert removes power on the next edge. Power never rises without an armed power-on command. Power stays off while a fault is latched. The voltage select never moves while power is on. The fault flag falls only after a clear command. The exact acceptance threshold of the filter, the seven-edge latency, the accumulation of mask bits across groups, the refusal to clear while an alert is still held and the per-device expansion can only be shown by the bench scenarios. Those scenarios drive pulses of chosen lengths and compare the status word against values the bench computes itself.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_TRIP = 2'd2
  } pwr_state_t;

  localparam logic [2:0] OP_PWR_ON  = 3'd1;
  localparam logic [2:0] OP_PWR_OFF = 3'd2;
  localparam logic [2:0] OP_SET_V   = 3'd3;
  localparam logic [2:0] OP_CLR     = 3'd4;

  // group index covering a given FPGA
  function automatic int unsigned group_of(input int unsigned fpga, input int unsigned per_grp);
    return fpga / per_grp;
  endfunction

  // debounce counter width for a required run length
  function automatic int unsigned run_cnt_w(input int unsigned run_len);
    return (run_len > 1) ? $clog2(run_len) : 1;
  endfunction

endpackage

// File: rtl/alert_filter.sv
module alert_filter #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alert_n,
  output logic sync_active,
  output logic accepted
);
  localparam int unsigned CW = sup_pkg::run_cnt_w(RUN_LEN);
  localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

  logic s1_n, s2_n;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_n <= 1'b1;
      s2_n <= 1'b1;
    end else begin
      s1_n <= alert_n;
      s2_n <= s1_n;
    end
  end

  assign sync_active = ~s2_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      accepted <= 1'b0;
    end else begin
      if (!sync_active)      run_q <= '0;
      else if (run_q != TOP) run_q <= run_q + 1'b1;
      accepted <= sync_active && (run_q == TOP);
    end
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import sup_pkg::*;
#(
  parameter int unsigned NGRP = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic [NGRP-1:0] acc,
  input  logic            any_sync_active,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic            cmd_data,
  output logic            pwr_on,
  output logic            vsel,
  output logic            err,
  output logic [NGRP-1:0] mask,
  output logic            trip_evt,
  output logic            clear_evt
);
  pwr_state_t st_q, st_d;

  logic on_req, off_req, clr_req, v_req;
  assign on_req  = cmd_valid && (cmd_op == OP_PWR_ON);
  assign off_req = cmd_valid && (cmd_op == OP_PWR_OFF);
  assign clr_req = cmd_valid && (cmd_op == OP_CLR);
  assign v_req   = cmd_valid && (cmd_op == OP_SET_V);

  assign trip_evt  = armed && (|acc);
  assign clear_evt = !trip_evt && clr_req && (st_q == ST_TRIP) && !any_sync_active;

  always_comb begin
    st_d = st_q;
    if (trip_evt) begin
      st_d = ST_TRIP;
    end else begin
      unique case (st_q)
        ST_OFF:  if (on_req && armed) st_d = ST_ON;
        ST_ON:   if (off_req)         st_d = ST_OFF;
        ST_TRIP: if (clear_evt)       st_d = ST_OFF;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
      mask <= '0;
      vsel <= 1'b0;
      err  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (trip_evt)       mask <= mask | acc;
      else if (clear_evt) mask <= '0;
      if (v_req) begin
        if (st_q == ST_ON) err <= 1'b1;
        else begin
          vsel <= cmd_data;
          err  <= 1'b0;
        end
      end
    end
  end

  assign pwr_on = (st_q == ST_ON);
endmodule

// File: rtl/pwr_thermal_sup.sv
module pwr_thermal_sup
  import sup_pkg::*;
#(
  parameter int unsigned NGRP         = 5,
  parameter int unsigned FPGA_PER_GRP = 4,
  parameter int unsigned RUN_LEN      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sensors_armed,
  input  logic [NGRP-1:0]              alert_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic                         cmd_data,
  output logic                         main_pwr_en,
  output logic                         io_vsel,
  output logic                         fault_flag,
  output logic [NGRP*FPGA_PER_GRP-1:0] fpga_hot,
  output logic [NGRP+2:0]              status
);
  localparam int unsigned NFPGA = NGRP * FPGA_PER_GRP;

  logic [NGRP-1:0] sync_act, acc, mask;
  logic err, trip_evt, clear_evt;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_filt
      alert_filter #(.RUN_LEN(RUN_LEN)) filt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alert_n    (alert_n[g]),
        .sync_active(sync_act[g]),
        .accepted   (acc[g])
      );
    end
  endgenerate

  pwr_seq_fsm #(.NGRP(NGRP)) fsm_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .armed          (sensors_armed),
    .acc            (acc),
    .any_sync_active(|sync_act),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_data       (cmd_data),
    .pwr_on         (main_pwr_en),
    .vsel           (io_vsel),
    .err            (err),
    .mask           (mask),
    .trip_evt       (trip_evt),
    .clear_evt      (clear_evt)
  );

  genvar j;
  generate
    for (j = 0; j < NFPGA; j++) begin : g_map
      assign fpga_hot[j] = mask[group_of(j, FPGA_PER_GRP)];
    end
  endgenerate

  assign fault_flag = |mask;
  assign status     = {err, mask, io_vsel, main_pwr_en};
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int unsigned NGRP = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sensors_armed,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic            main_pwr_en,
  input logic            io_vsel,
  input logic            fault_flag,
  input logic            trip_evt,
  input logic [NGRP-1:0] mask
);
  // R5: accepted alert removes power on the next edge
  p_trip_cuts_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> !main_pwr_en);

  // R2, R3: power only rises from an armed power-on command
  p_rise_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_pwr_en) |-> $past(cmd_valid && cmd_op == 3'd1 && sensors_armed));

  // R6: no power while a fault is latched
  p_fault_keeps_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> !main_pwr_en);

  // R8: selection frozen while powered
  p_vsel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    main_pwr_en |=> $stable(io_vsel));

  // R7: fault only leaves through a clear command
  p_clear_by_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> $past(cmd_valid && cmd_op == 3'd4));

  // R5: mask bits never drop while fault stays
  p_mask_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && $past(fault_flag) |-> (($past(mask) & ~mask) == '0));
endmodule

bind pwr_thermal_sup sup_checker #(.NGRP(NGRP)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sensors_armed(sensors_armed),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .main_pwr_en  (main_pwr_en),
  .io_vsel      (io_vsel),
  .fault_flag   (fault_flag),
  .trip_evt     (trip_evt),
  .mask         (mask)
);

// File: tb/pwr_thermal_sup_tb.sv
module pwr_thermal_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic armed = 1'b0;
  logic [NG-1:0] alert_n = '1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic cmd_data = 1'b0;
  logic main_pwr_en, io_vsel, fault_flag;
  logic [19:0] fpga_hot;
  logic [7:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_thermal_sup dut_i (
    .clk(clk), .rst_n(rst_n), .sensors_armed(armed), .alert_n(alert_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .main_pwr_en(main_pwr_en), .io_vsel(io_vsel), .fault_flag(fault_flag),
    .fpga_hot(fpga_hot), .status(status)
  );

  function automatic logic [7:0] exp_status(bit err, logic [4:0] m, bit v, bit p);
    logic [7:0] s;
    s[0] = p; s[1] = v; s[6:2] = m; s[7] = err;
    return s;
  endfunction

  function automatic logic [19:0] exp_hot(logic [4:0] m);
    logic [19:0] h = '0;
    for (int k = 0; k < 20; k++) if (m[k >> 2]) h[k] = 1'b1;
    return h;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [2:0] op, bit d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 status", 32'(status), 32'(exp_status(0, 5'b0, 0, 0)));
    check("R1 fault", 32'(fault_flag), 32'd0);
  endtask

  task automatic t_unarmed;
    send(3'd1, 0);
    check("R3 on while unarmed", 32'(main_pwr_en), 32'd0);
    alert_n[0] = 1'b0;
    wait_n(10);
    check("R10 unarmed alert", 32'(status), 32'(exp_status(0, 5'b0, 0, 0)));
    alert_n[0] = 1'b1;
    wait_n(4);
  endtask

  task automatic t_power;
    send(3'd1, 0);
    check("R2 on", 32'(status), 32'(exp_status(0, 5'b0, 0, 1)));
    send(3'd2, 0);
    check("R2 off", 32'(status), 32'(exp_status(0, 5'b0, 0, 0)));
  endtask

  task automatic t_vsel;
    send(3'd3, 1);
    check("R8 set off", 32'(status), 32'(exp_status(0, 5'b0, 1, 0)));
    send(3'd1, 0);
    send(3'd3, 0);
    check("R8 reject on", 32'(status), 32'(exp_status(1, 5'b0, 1, 1)));
    send(3'd2, 0);
    send(3'd3, 0);
    check("R8 err cleared", 32'(status), 32'(exp_status(0, 5'b0, 0, 0)));
  endtask

  task automatic t_glitch;
    send(3'd1, 0);
    alert_n[1] = 1'b0;
    wait_n(3);
    alert_n[1] = 1'b1;
    wait_n(10);
    check("R4 3-cycle rejected", 32'(status), 32'(exp_status(0, 5'b0, 0, 1)));
  endtask

  task automatic t_trip;
    alert_n[2] = 1'b0;
    wait_n(6);
    check("R4 on after 6 edges", 32'(main_pwr_en), 32'd1);
    wait_n(1);
    check("R4 off after 7 edges", 32'(main_pwr_en), 32'd0);
    check("R5 mask g2", 32'(status), 32'(exp_status(0, 5'b00100, 0, 0)));
    check("R9 hot g2", 32'(fpga_hot), 32'(exp_hot(5'b00100)));
    alert_n[4] = 1'b0;
    wait_n(8);
    check("R5 mask accumulates", 32'(status), 32'(exp_status(0, 5'b10100, 0, 0)));
    check("R9 hot g2 g4", 32'(fpga_hot), 32'(exp_hot(5'b10100)));
    send(3'd1, 0);
    check("R6 on ignored", 32'(main_pwr_en), 32'd0);
    alert_n[4] = 1'b1;
    wait_n(4);
    send(3'd4, 0);
    check("R7 clear rejected", 32'(status), 32'(exp_status(0, 5'b10100, 0, 0)));
    alert_n[2] = 1'b1;
    wait_n(4);
    send(3'd4, 0);
    check("R7 clear accepted", 32'(status), 32'(exp_status(0, 5'b0, 0, 0)));
    check("R7 flag low", 32'(fault_flag), 32'd0);
    send(3'd1, 0);
    check("R2 on after clear", 32'(main_pwr_en), 32'd1);
  endtask

  task automatic t_pulse4;
    alert_n[0] = 1'b0;
    wait_n(4);
    alert_n[0] = 1'b1;
    wait_n(6);
    check("R4 4-cycle accepted", 32'(status), 32'(exp_status(0, 5'b00001, 0, 0)));
    check("R9 hot g0", 32'(fpga_hot), 32'(exp_hot(5'b00001)));
    send(3'd4, 0);
    check("R7 clear", 32'(fault_flag), 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset;
    t_unarmed;
    armed = 1'b1;
    wait_n(1);
    t_power;
    t_vsel;
    t_glitch;
    t_trip;
    send(3'd2, 0);
    t_pulse4;
    wait_n(2);
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule